// File: doc/BRIEF.md
# Dualoct Transfer Deserializer and Serializer

This block sits between an 18-bit double-data-rate memory data channel and a 128-bit internal datapath. Each transfer on the channel carries two data bytes and one parity bit for each byte. Both clock edges carry a transfer. The two edges are modelled as a pair of 18-bit samples per clock cycle: a rising-edge sample and a falling-edge sample. Eight transfers, taken over four clock cycles, make one 16-byte dualoct. The dualoct is the smallest unit that can be moved, so no burst is ever shorter or longer than eight transfers.

The read side is a state machine with three states. It starts in RD_IDLE. A read request in RD_IDLE latches a 6-bit column address (one of 64 dualocts in a row) and moves to RD_WAIT. RD_WAIT spends `LAT` cycles there to model the memory's deep pipeline. It then moves to RD_CAPT, where it captures four edge pairs, and returns to RD_IDLE. After RD_CAPT the block presents the assembled 128-bit word, the 16 received parity bits and an optional parity-error flag, together with a one-cycle valid strobe.

The write side has two states. WR_IDLE accepts a dualoct and moves to WR_SEND. WR_SEND emits four edge pairs, with parity generated under the configured policy, and then returns to WR_IDLE.

Top module: `dualoct_link`

## Requirements
- R1: After reset, rd_valid, rd_perr and tx_vld are 0 and wr_ready is 1.
- R2: A rd_req sampled in RD_IDLE is followed by exactly LAT wait cycles, then four capture cycles. rd_valid is high for exactly one cycle, the cycle right after the fourth capture cycle.
- R3: In capture cycle k (0..3), rx_rise carries transfer 2k and rx_fall carries transfer 2k+1. In transfer j, bits [7:0] go to byte 2j and bits [15:8] go to byte 2j+1 of rd_data, where byte n is rd_data[8n+7:8n]. Bit 16 goes to rd_par[2j] and bit 17 goes to rd_par[2j+1].
- R4: rd_col is latched when the request is accepted and is shown on rd_col_q while rd_valid is high, whatever rd_col does afterwards.
- R5: rd_req is ignored while a read is in RD_WAIT or RD_CAPT. The timing and data of the read in flight do not change, and no extra rd_valid follows.
- R6: rd_perr is high only together with rd_valid. It is 1 when par_check is high in the last capture cycle and at least one of the 16 received parity bits disagrees with its byte. With par_check low it is 0.
- R7: The parity policy is set by ODD_PARITY. When it is 1 (the default), a byte plus its parity bit holds an odd number of ones. When it is 0, the count is even.
- R8: A wr_req seen while wr_ready is 1 loads wr_data and wr_col. In each of the next four cycles, tx_vld is 1 and wr_ready is 0. Cycle k drives transfers 2k on tx_rise and 2k+1 on tx_fall, using the byte and parity-bit layout of R3 applied to wr_data, with parity generated per R7. tx_col holds the latched column.
- R9: wr_req while wr_ready is 0 is ignored. The burst in flight keeps its original data and column, and no extra burst follows.
- R10: Every write burst has exactly four tx_vld cycles and is followed by at least one cycle with tx_vld low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_check | input | 1 | Enables the read parity check |
| rd_req | input | 1 | Read request |
| rd_col | input | 6 | Read column (dualoct index within the row) |
| rx_rise | input | 18 | Rising-edge transfer sample |
| rx_fall | input | 18 | Falling-edge transfer sample |
| rd_valid | output | 1 | One-cycle strobe for the assembled dualoct |
| rd_data | output | 128 | Assembled dualoct data |
| rd_par | output | 16 | Received parity bits, one per byte |
| rd_perr | output | 1 | Parity error in the dualoct |
| rd_col_q | output | 6 | Column of the delivered dualoct |
| wr_req | input | 1 | Write request |
| wr_data | input | 128 | Dualoct to send |
| wr_col | input | 6 | Write column |
| wr_ready | output | 1 | Write side idle and able to accept |
| tx_vld | output | 1 | Transfer pair valid |
| tx_rise | output | 18 | Rising-edge transfer out |
| tx_fall | output | 18 | Falling-edge transfer out |
| tx_col | output | 6 | Column of the burst being sent |

## Verification
The assertions check the following on every cycle:
- the read strobe never lasts more than one cycle;
- a parity error never appears without the strobe;
- write transfers appear only while the write side is busy;
- an accepted write always starts a burst of exactly four beats, followed by a gap;
- the generated parity bits match the outgoing bytes.

Only the bench scenarios can show the rest:
- the exact latency of LAT plus four cycles;
- the byte and parity-bit placement in rd_data and rd_par;
- column latching;
- that requests arriving mid-burst change nothing at the outputs;
- the difference between checked and unchecked parity errors, including an error in the last byte.

// File: rtl/dualoct_pkg.sv
package dualoct_pkg;
    localparam int BYTE_W      = 8;
    localparam int XFER_BYTES  = 2;
    localparam int XFERS       = 8;
    localparam int EDGES       = 2;
    localparam int XFER_DATA_W = XFER_BYTES * BYTE_W;
    localparam int XFER_W      = XFER_DATA_W + XFER_BYTES;
    localparam int WORD_W      = XFERS * XFER_DATA_W;
    localparam int PAR_W       = XFERS * XFER_BYTES;
    localparam int CYC         = XFERS / EDGES;
    localparam int CYC_W       = $clog2(CYC);
    localparam int PAIR_W      = EDGES * XFER_W;
    localparam int PAIR_DATA_W = EDGES * XFER_DATA_W;

    // Parity bit for one byte under the chosen policy.
    function automatic logic par_of(input logic [BYTE_W-1:0] b, input logic odd);
        return odd ? ~(^b) : (^b);
    endfunction

    // Build one transfer: data in the low bits, one parity bit per byte on top.
    function automatic logic [XFER_W-1:0] enc_xfer(input logic [XFER_DATA_W-1:0] d,
                                                    input logic odd);
        logic [XFER_W-1:0] x;
        x[XFER_DATA_W-1:0] = d;
        for (int b = 0; b < XFER_BYTES; b++)
            x[XFER_DATA_W + b] = par_of(d[b*BYTE_W +: BYTE_W], odd);
        return x;
    endfunction
endpackage

// File: rtl/dualoct_rd.sv
module dualoct_rd
    import dualoct_pkg::*;
#(
    parameter int LAT        = 20,
    parameter int COL_W      = 6,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [COL_W-1:0]  col,
    input  logic              par_check,
    input  logic [XFER_W-1:0] rise,
    input  logic [XFER_W-1:0] fall,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    output logic [PAR_W-1:0]  par,
    output logic              perr,
    output logic [COL_W-1:0]  col_q
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CYC_W-1:0] LAST_BEAT = CYC_W'(CYC - 1);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(LAT - 1);

    typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_CAPT} rd_state_t;

    rd_state_t              st, st_nx;
    logic [CNT_W-1:0]       wcnt;
    logic [CYC_W-1:0]       beat;
    logic [PAIR_W-1:0]      pair;
    logic [EDGES*XFER_BYTES-1:0] lane_err;
    logic                   err_acc, err_now;

    assign pair = {fall, rise};

    // One mismatch flag per byte lane of the current edge pair.
    for (genvar t = 0; t < EDGES; t++) begin : g_edge
        for (genvar b = 0; b < XFER_BYTES; b++) begin : g_lane
            assign lane_err[t*XFER_BYTES + b] =
                pair[t*XFER_W + XFER_DATA_W + b] !=
                par_of(pair[t*XFER_W + b*BYTE_W +: BYTE_W], ODD_PARITY);
        end
    end

    assign err_now = ((beat == '0) ? 1'b0 : err_acc) | (|lane_err);

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: if (req)                st_nx = RD_WAIT;
            RD_WAIT: if (wcnt == LAST_WAIT)  st_nx = RD_CAPT;
            RD_CAPT: if (beat == LAST_BEAT)  st_nx = RD_IDLE;
            default:                         st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RD_IDLE;
            wcnt <= '0;
            beat <= '0;
        end else begin
            st   <= st_nx;
            wcnt <= (st == RD_WAIT) ? wcnt + 1'b1 : '0;
            beat <= (st == RD_CAPT) ? beat + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            perr    <= 1'b0;
            err_acc <= 1'b0;
            data    <= '0;
            par     <= '0;
            col_q   <= '0;
        end else begin
            valid <= (st == RD_CAPT) && (beat == LAST_BEAT);
            perr  <= (st == RD_CAPT) && (beat == LAST_BEAT) && par_check && err_now;
            if (st == RD_IDLE && req)
                col_q <= col;
            if (st == RD_CAPT) begin
                err_acc <= err_now;
                for (int t = 0; t < EDGES; t++) begin
                    data[(int'(beat)*EDGES + t)*XFER_DATA_W +: XFER_DATA_W] <=
                        pair[t*XFER_W +: XFER_DATA_W];
                    par[(int'(beat)*EDGES + t)*XFER_BYTES +: XFER_BYTES] <=
                        pair[t*XFER_W + XFER_DATA_W +: XFER_BYTES];
                end
            end
        end
    end
endmodule

// File: rtl/dualoct_wr.sv
module dualoct_wr
    import dualoct_pkg::*;
#(
    parameter int COL_W      = 6,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] word,
    input  logic [COL_W-1:0]  col,
    output logic              ready,
    output logic              vld,
    output logic [XFER_W-1:0] rise,
    output logic [XFER_W-1:0] fall,
    output logic [COL_W-1:0]  col_q
);
    localparam logic [CYC_W-1:0] LAST_BEAT = CYC_W'(CYC - 1);

    typedef enum logic {WR_IDLE, WR_SEND} wr_state_t;

    wr_state_t          st, st_nx;
    logic [CYC_W-1:0]   beat;
    logic [WORD_W-1:0]  word_q;
    logic [PAIR_DATA_W-1:0] slice;

    always_comb begin
        st_nx = st;
        unique case (st)
            WR_IDLE: if (req)               st_nx = WR_SEND;
            WR_SEND: if (beat == LAST_BEAT) st_nx = WR_IDLE;
            default:                        st_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            beat   <= '0;
            word_q <= '0;
            col_q  <= '0;
        end else begin
            st   <= st_nx;
            beat <= (st == WR_SEND) ? beat + 1'b1 : '0;
            if (st == WR_IDLE && req) begin
                word_q <= word;
                col_q  <= col;
            end
        end
    end

    assign slice = word_q[int'(beat)*PAIR_DATA_W +: PAIR_DATA_W];

    always_comb begin
        ready = (st == WR_IDLE);
        vld   = (st == WR_SEND);
        rise  = '0;
        fall  = '0;
        if (st == WR_SEND) begin
            rise = enc_xfer(slice[0 +: XFER_DATA_W], ODD_PARITY);
            fall = enc_xfer(slice[XFER_DATA_W +: XFER_DATA_W], ODD_PARITY);
        end
    end
endmodule

// File: rtl/dualoct_link.sv
module dualoct_link
    import dualoct_pkg::*;
#(
    parameter int LAT        = 20,
    parameter int COL_W      = 6,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_check,
    input  logic              rd_req,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [XFER_W-1:0] rx_rise,
    input  logic [XFER_W-1:0] rx_fall,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [PAR_W-1:0]  rd_par,
    output logic              rd_perr,
    output logic [COL_W-1:0]  rd_col_q,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [COL_W-1:0]  wr_col,
    output logic              wr_ready,
    output logic              tx_vld,
    output logic [XFER_W-1:0] tx_rise,
    output logic [XFER_W-1:0] tx_fall,
    output logic [COL_W-1:0]  tx_col
);
    dualoct_rd #(.LAT(LAT), .COL_W(COL_W), .ODD_PARITY(ODD_PARITY)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rd_req),
        .col       (rd_col),
        .par_check (par_check),
        .rise      (rx_rise),
        .fall      (rx_fall),
        .valid     (rd_valid),
        .data      (rd_data),
        .par       (rd_par),
        .perr      (rd_perr),
        .col_q     (rd_col_q)
    );

    dualoct_wr #(.COL_W(COL_W), .ODD_PARITY(ODD_PARITY)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (wr_req),
        .word  (wr_data),
        .col   (wr_col),
        .ready (wr_ready),
        .vld   (tx_vld),
        .rise  (tx_rise),
        .fall  (tx_fall),
        .col_q (tx_col)
    );
endmodule

// File: rtl/dualoct_link_chk.sv
module dualoct_link_chk
    import dualoct_pkg::*;
#(
    parameter bit ODD_PARITY = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_perr,
    input logic              wr_req,
    input logic              wr_ready,
    input logic              tx_vld,
    input logic [XFER_W-1:0] tx_rise,
    input logic [XFER_W-1:0] tx_fall
);
    logic [CYC_W-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= tx_vld ? run + 1'b1 : '0;
    end

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_perr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_perr |-> rd_valid);

    a_r8_tx_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> !wr_ready);

    a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready) |=> tx_vld);

    a_r10_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && run == CYC_W'(CYC - 1)) |=> !tx_vld);

    a_r10_burst_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_vld) |-> ($past(run) == CYC_W'(CYC - 1)));

    a_r7_tx_parity: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (tx_rise[XFER_DATA_W]     == par_of(tx_rise[BYTE_W-1:0], ODD_PARITY) &&
                    tx_fall[XFER_DATA_W + 1] == par_of(tx_fall[XFER_DATA_W-1:BYTE_W], ODD_PARITY)));
endmodule

bind dualoct_link dualoct_link_chk #(.ODD_PARITY(ODD_PARITY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_perr  (rd_perr),
    .wr_req   (wr_req),
    .wr_ready (wr_ready),
    .tx_vld   (tx_vld),
    .tx_rise  (tx_rise),
    .tx_fall  (tx_fall)
);

// File: tb/dualoct_link_tb.sv
module dualoct_link_tb;
    localparam int CLK_NS = 10;
    localparam int LAT    = 20;
    localparam bit ODD    = 1'b1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         par_check = 1'b0;
    logic         rd_req = 1'b0;
    logic [5:0]   rd_col = '0;
    logic [17:0]  rx_rise = '0, rx_fall = '0;
    logic         rd_valid, rd_perr;
    logic [127:0] rd_data;
    logic [15:0]  rd_par;
    logic [5:0]   rd_col_q;
    logic         wr_req = 1'b0;
    logic [127:0] wr_data = '0;
    logic [5:0]   wr_col = '0;
    logic         wr_ready, tx_vld;
    logic [17:0]  tx_rise, tx_fall;
    logic [5:0]   tx_col;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dualoct_link #(.LAT(LAT), .COL_W(6), .ODD_PARITY(ODD)) u_dut (
        .clk(clk), .rst_n(rst_n), .par_check(par_check),
        .rd_req(rd_req), .rd_col(rd_col), .rx_rise(rx_rise), .rx_fall(rx_fall),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
        .rd_perr(rd_perr), .rd_col_q(rd_col_q),
        .wr_req(wr_req), .wr_data(wr_data), .wr_col(wr_col),
        .wr_ready(wr_ready), .tx_vld(tx_vld), .tx_rise(tx_rise),
        .tx_fall(tx_fall), .tx_col(tx_col)
    );

    function automatic logic pbit(input logic [7:0] b);
        return ODD ? ~(^b) : (^b);
    endfunction

    function automatic logic [17:0] mk(input logic [15:0] d, input logic [1:0] flip);
        return {pbit(d[15:8]) ^ flip[1], pbit(d[7:0]) ^ flip[0], d};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Read burst: flip marks parity bits sent wrong; poke keeps rd_req high mid-burst.
    task automatic do_read(input logic [127:0] dw, input logic [15:0] flip,
                           input bit chk_on, input logic [5:0] col, input bit poke);
        logic [17:0] xf [8];
        logic [15:0] exp_par;
        bit saw;
        for (int j = 0; j < 8; j++) begin
            xf[j] = mk(dw[16*j +: 16], flip[2*j +: 2]);
            exp_par[2*j +: 2] = xf[j][17:16];
        end
        @(negedge clk);
        rd_req = 1'b1; rd_col = col; par_check = chk_on;
        @(posedge clk);
        @(negedge clk);
        rd_req = poke; rd_col = ~col;
        for (int i = 0; i < LAT; i++) begin
            @(posedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_rise = xf[2*k]; rx_fall = xf[2*k+1]; rd_req = poke;
            if (k == 0) check(rd_valid == 1'b0, "R2", "no valid before data", 128'(rd_valid), 128'(0));
            @(posedge clk);
        end
        @(negedge clk);
        rd_req = 1'b0; rx_rise = 18'($urandom); rx_fall = 18'($urandom);
        check(rd_valid == 1'b1, "R2", "valid after 4th capture", 128'(rd_valid), 128'(1));
        check(rd_data == dw, "R3", "rd_data", rd_data, dw);
        check(rd_par == exp_par, "R3", "rd_par", 128'(rd_par), 128'(exp_par));
        check(rd_perr == (chk_on && (flip != 0)), "R6", "rd_perr",
              128'(rd_perr), 128'(chk_on && (flip != 0)));
        check(rd_col_q == col, "R4", "rd_col_q", 128'(rd_col_q), 128'(col));
        @(negedge clk);
        check(rd_valid == 1'b0, "R2", "valid one cycle", 128'(rd_valid), 128'(0));
        if (poke) begin
            saw = 1'b0;
            for (int i = 0; i < LAT + 8; i++) begin
                @(negedge clk);
                if (rd_valid) saw = 1'b1;
            end
            check(!saw, "R5", "no extra read", 128'(saw), 128'(0));
        end
    endtask

    task automatic do_write(input logic [127:0] w, input logic [5:0] col, input bit poke);
        logic [17:0] er, ef;
        @(negedge clk);
        check(wr_ready == 1'b1, "R8", "ready before accept", 128'(wr_ready), 128'(1));
        wr_req = 1'b1; wr_data = w; wr_col = col;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_req = poke; wr_data = ~w; wr_col = ~col;
            er = mk(w[32*k +: 16], 2'b00);
            ef = mk(w[32*k+16 +: 16], 2'b00);
            check(tx_vld == 1'b1 && wr_ready == 1'b0, "R8", "busy beat",
                  128'({tx_vld, wr_ready}), 128'(2'b10));
            check(tx_rise == er, poke ? "R9" : "R8", "tx_rise", 128'(tx_rise), 128'(er));
            check(tx_fall == ef, "R7", "tx_fall", 128'(tx_fall), 128'(ef));
            check(tx_col == col, "R8", "tx_col", 128'(tx_col), 128'(col));
            @(posedge clk);
        end
        @(negedge clk);
        wr_req = 1'b0;
        check(tx_vld == 1'b0 && wr_ready == 1'b1, "R10", "burst ends after 4",
              128'({tx_vld, wr_ready}), 128'(2'b01));
        @(negedge clk);
        check(tx_vld == 1'b0, "R9", "no extra burst", 128'(tx_vld), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0d0c));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_valid == 0 && rd_perr == 0 && tx_vld == 0 && wr_ready == 1, "R1", "reset state",
              128'({rd_valid, rd_perr, tx_vld, wr_ready}), 128'(4'b0001));
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 0 && tx_vld == 0 && wr_ready == 1, "R1", "after release",
              128'({rd_valid, tx_vld, wr_ready}), 128'(3'b001));

        // Directed reads: all zeros, all ones, column boundaries
        do_read('0, 16'h0000, 1'b1, 6'h00, 1'b0);
        do_read('1, 16'h0000, 1'b1, 6'h3f, 1'b0);
        // Byte-index pattern to expose ordering (R3)
        begin
            logic [127:0] ramp;
            for (int n = 0; n < 16; n++) ramp[8*n +: 8] = 8'(n * 17 + 1);
            do_read(ramp, 16'h0000, 1'b0, 6'h15, 1'b0);
        end
        // Random reads with clean parity, check randomly on or off
        for (int i = 0; i < 4; i++)
            do_read(rnd128(), 16'h0000, 1'($urandom), 6'($urandom), 1'b0);
        // Parity errors: R6 and R7 checked on receive
        do_read(rnd128(), 16'h0001, 1'b1, 6'h01, 1'b0);
        do_read(rnd128(), 16'h8000, 1'b1, 6'h02, 1'b0);
        do_read(rnd128(), 16'h0240, 1'b0, 6'h03, 1'b0);
        do_read(rnd128(), 16'($urandom) | 16'h0100, 1'b1, 6'h04, 1'b0);
        // Requests during an active read are ignored (R5)
        do_read(rnd128(), 16'h0000, 1'b1, 6'h2a, 1'b1);

        // Writes
        do_write('0, 6'h00, 1'b0);
        do_write('1, 6'h3f, 1'b0);
        for (int i = 0; i < 3; i++)
            do_write(rnd128(), 6'($urandom), 1'b0);
        do_write(rnd128(), 6'h11, 1'b1);
        do_write(rnd128(), 6'h22, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule